// File: doc/BRIEF.md
# Dual Sample-Hold Conversion Controller

This block manages two sample-and-hold input channels that share a single ADC with the voltage-channel sequencer. External trigger pulses are routed to the channels. In single routing, trigger line 0 starts both channels. In dual routing, each channel has its own trigger line. A triggered, enabled channel then waits for a conversion slot and asks the converter for it through a valid/ready handshake.

When the converter reports a finished conversion, the 14-bit result is packed into a 16-bit word. The word is left-justified, or right-justified with sign extension, and written to the channel's fixed slot in the result buffer. After the write, an optional discharge strobe drives the channel's input pins. Sticky completion flags feed a masked interrupt output. Which events set a flag depends on the routing mode.

Slot timing is based on a sequence period of `PERIOD_TICKS` clocks, with one slot per channel in each period. A fast setting lets channel 0 request the converter at any time. While channel 0 is in fast operation, voltage conversions are held off.

Top module: `shdual_ctrl`

## Requirements
- R1: With the routing bit clear (single mode), a pulse on `trig_in[0]` starts every enabled channel, and a pulse on `trig_in[1]` alone starts nothing.
- R2: With the routing bit set (dual mode), `trig_in[0]` starts only channel 0 and `trig_in[1]` starts only channel 1.
- R3: A channel whose enable bit is clear never raises `adc_req_valid` with its ID on `adc_req_ch` (0 or 1) and never produces a buffer write.
- R4: A finished conversion is written one clock after `adc_done`. Channel 0's result goes to buffer address `SLOT0` (23) and channel 1's result goes to `SLOT1` (24).
- R5: With a channel's justify bit set, the word is result[13:0] in bits [15:2] with bits [1:0] zero. With the bit clear, the result is in bits [13:0] and bits [15:14] repeat bit 13.
- R6: In normal mode, each channel receives at most one converter slot per `PERIOD_TICKS` clocks. Outside those slots, and when the converter is idle, `volt_gnt` follows `volt_req`.
- R7: In fast mode, channel 0 requests without waiting for a slot and takes precedence over voltage conversions. `volt_gnt` is never high while `adc_req_valid` is high.
- R8: If a channel's discharge bit is set when its result is accepted, `dis_strobe[ch]` is high for `DIS_CYCLES` clocks, starting together with the buffer write. If the bit is clear, no strobe is issued.
- R9: A trigger that arrives while the channel is waiting, converting or discharging is ignored.
- R10: In dual mode, a completed conversion on channel i sets `irq_flags[i]`.
- R11: In single mode, `irq_flags[0]` is set only once every enabled channel has completed, and `irq_flags[1]` is never set.
- R12: Flags are sticky until cleared by a 1 on the matching `flag_clr` bit. `irq` is high when any flag is set and its interrupt-enable bit is set.
- R13: Control word layout: bit0 enable ch0, bit1 enable ch1, bit2 dual routing, bit3 left-justify ch0, bit4 left-justify ch1, bit5 irq enable ch0, bit6 irq enable ch1, bit7 discharge ch0, bit8 discharge ch1, bit9 fast. Bits 15:10 read as zero. After reset all bits, flags and outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Current control word |
| flag_clr | input | 2 | Write-1-to-clear for the completion flags |
| trig_in | input | 2 | External sample trigger pulses |
| volt_req | input | 1 | Voltage sequencer wants the converter |
| volt_gnt | output | 1 | Voltage sequencer may use the converter this clock |
| adc_req_valid | output | 1 | Sample-hold conversion request |
| adc_req_ready | input | 1 | Converter accepts the request |
| adc_req_ch | output | 1 | Requesting channel ID |
| adc_done | input | 1 | Conversion finished pulse |
| adc_done_ch | input | 1 | Channel ID of the finished conversion |
| adc_result | input | 14 | Raw conversion result |
| buf_we | output | 1 | Result buffer write strobe |
| buf_addr | output | ADDR_W | Result buffer address |
| buf_wdata | output | 16 | Formatted result |
| dis_strobe | output | 2 | Per-channel pin discharge strobe |
| irq_flags | output | 2 | Sticky completion flags |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with `PERIOD_TICKS` = 16 and `DIS_CYCLES` = 3, so one sequence period is short. Windows of eight periods can then compare the slot-limited normal rate against the unthrottled fast rate, and many retrigger and drain rounds fit in a short run. The short discharge makes the strobe length easy to count. A converter model with random acceptance delay and random results checks every buffer word against a packing function.

// File: rtl/shdual_pkg.sv
package shdual_pkg;
    localparam int RES_W  = 14;
    localparam int WORD_W = 16;
    localparam int NCH    = 2;

    localparam int CB_EN0  = 0;
    localparam int CB_EN1  = 1;
    localparam int CB_DUAL = 2;
    localparam int CB_ALN0 = 3;
    localparam int CB_ALN1 = 4;
    localparam int CB_IE0  = 5;
    localparam int CB_IE1  = 6;
    localparam int CB_DIS0 = 7;
    localparam int CB_DIS1 = 8;
    localparam int CB_FAST = 9;
    localparam logic [WORD_W-1:0] CTRL_MASK = 16'h03FF;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_PEND,
        CH_CONV,
        CH_DISC
    } ch_state_e;

    function automatic logic [WORD_W-1:0] pack_result(input logic [RES_W-1:0] raw,
                                                       input logic left);
        if (left)
            pack_result = {raw, {(WORD_W-RES_W){1'b0}}};
        else
            pack_result = {{(WORD_W-RES_W){raw[RES_W-1]}}, raw};
    endfunction
endpackage

// File: rtl/shdual_chan.sv
module shdual_chan
    import shdual_pkg::*;
#(
    parameter int DIS_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic trig,
    input  logic issue,
    input  logic done,
    input  logic dis_en,
    output logic pending,
    output logic converting,
    output logic strobe,
    output logic complete
);
    localparam int CW = $clog2(DIS_CYCLES + 1);

    typedef struct packed {
        ch_state_e       st;
        logic [CW-1:0]   cnt;
    } chan_reg_t;

    chan_reg_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        complete = 1'b0;
        case (r_q.st)
            CH_IDLE: if (trig) r_d.st = CH_PEND;
            CH_PEND: if (issue) r_d.st = CH_CONV;
            CH_CONV: begin
                if (done) begin
                    complete = 1'b1;
                    if (dis_en) begin
                        r_d.st  = CH_DISC;
                        r_d.cnt = CW'(DIS_CYCLES - 1);
                    end else begin
                        r_d.st = CH_IDLE;
                    end
                end
            end
            CH_DISC: begin
                if (r_q.cnt == '0) r_d.st = CH_IDLE;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            default: r_d.st = CH_IDLE;
        endcase
        if (!enable) begin
            r_d.st   = CH_IDLE;
            r_d.cnt  = '0;
            complete = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= CH_IDLE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pending    = enable && (r_q.st == CH_PEND);
    assign converting = (r_q.st == CH_CONV);
    assign strobe     = (r_q.st == CH_DISC);
endmodule

// File: rtl/shdual_arb.sv
module shdual_arb
    import shdual_pkg::*;
#(
    parameter int PERIOD_TICKS = 5000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fast,
    input  logic [NCH-1:0] pending,
    input  logic           conv_busy,
    input  logic           req_ready,
    input  logic           volt_req,
    output logic           req_valid,
    output logic           req_ch,
    output logic [NCH-1:0] issue,
    output logic           volt_gnt
);
    localparam int PW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;

    typedef struct packed {
        logic [PW-1:0]  cnt;
        logic [NCH-1:0] tok;
    } arb_reg_t;

    arb_reg_t a_d, a_q;
    logic [NCH-1:0] want;
    logic           wrap;

    always_comb begin
        a_d     = a_q;
        wrap    = (a_q.cnt == PW'(PERIOD_TICKS - 1));
        want[0] = pending[0] && (fast || a_q.tok[0]);
        want[1] = pending[1] && a_q.tok[1];

        req_valid = !conv_busy && (|want);
        req_ch    = !want[0];
        issue     = '0;
        if (req_valid && req_ready) issue[req_ch] = 1'b1;

        volt_gnt = volt_req && !req_valid && !conv_busy;

        a_d.tok = a_q.tok & ~issue;
        if (wrap) begin
            a_d.cnt = '0;
            a_d.tok = '1;
        end else begin
            a_d.cnt = a_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q.cnt <= '0;
            a_q.tok <= '1;
        end else begin
            a_q <= a_d;
        end
    end
endmodule

// File: rtl/shdual_ctrl.sv
module shdual_ctrl
    import shdual_pkg::*;
#(
    parameter int PERIOD_TICKS = 5000,
    parameter int DIS_CYCLES   = 4,
    parameter int ADDR_W       = 5,
    parameter int SLOT0        = 23,
    parameter int SLOT1        = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic [1:0]        flag_clr,
    input  logic [1:0]        trig_in,
    input  logic              volt_req,
    output logic              volt_gnt,
    output logic              adc_req_valid,
    input  logic              adc_req_ready,
    output logic              adc_req_ch,
    input  logic              adc_done,
    input  logic              adc_done_ch,
    input  logic [13:0]       adc_result,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [15:0]       buf_wdata,
    output logic [1:0]        dis_strobe,
    output logic [1:0]        irq_flags,
    output logic              irq
);
    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [NCH-1:0]    flags;
        logic [NCH-1:0]    seen;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } top_reg_t;

    top_reg_t t_d, t_q;

    logic [NCH-1:0] en_vec, aln_vec, ie_vec, dis_vec;
    logic [NCH-1:0] trig_route, done_vec, issue_vec;
    logic [NCH-1:0] pend_vec, conv_vec, strobe_vec, complete_vec;
    logic [NCH-1:0] seen_nxt;
    logic           dual_mode;

    assign en_vec    = {t_q.ctrl[CB_EN1],  t_q.ctrl[CB_EN0]};
    assign aln_vec   = {t_q.ctrl[CB_ALN1], t_q.ctrl[CB_ALN0]};
    assign ie_vec    = {t_q.ctrl[CB_IE1],  t_q.ctrl[CB_IE0]};
    assign dis_vec   = {t_q.ctrl[CB_DIS1], t_q.ctrl[CB_DIS0]};
    assign dual_mode = t_q.ctrl[CB_DUAL];

    assign trig_route[0] = trig_in[0];
    assign trig_route[1] = dual_mode ? trig_in[1] : trig_in[0];

    for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
        assign done_vec[gi] = adc_done && (adc_done_ch == 1'(gi));

        shdual_chan #(
            .DIS_CYCLES(DIS_CYCLES)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable    (en_vec[gi]),
            .trig      (trig_route[gi]),
            .issue     (issue_vec[gi]),
            .done      (done_vec[gi]),
            .dis_en    (dis_vec[gi]),
            .pending   (pend_vec[gi]),
            .converting(conv_vec[gi]),
            .strobe    (strobe_vec[gi]),
            .complete  (complete_vec[gi])
        );
    end

    shdual_arb #(
        .PERIOD_TICKS(PERIOD_TICKS)
    ) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast     (t_q.ctrl[CB_FAST]),
        .pending  (pend_vec),
        .conv_busy(|conv_vec),
        .req_ready(adc_req_ready),
        .volt_req (volt_req),
        .req_valid(adc_req_valid),
        .req_ch   (adc_req_ch),
        .issue    (issue_vec),
        .volt_gnt (volt_gnt)
    );

    always_comb begin
        t_d      = t_q;
        seen_nxt = '0;
        if (cfg_we) t_d.ctrl = cfg_wdata & CTRL_MASK;

        t_d.we = |complete_vec;
        if (complete_vec[0]) begin
            t_d.addr = ADDR_W'(SLOT0);
            t_d.data = pack_result(adc_result, aln_vec[0]);
        end else if (complete_vec[1]) begin
            t_d.addr = ADDR_W'(SLOT1);
            t_d.data = pack_result(adc_result, aln_vec[1]);
        end

        t_d.flags = t_q.flags & ~flag_clr;
        if (dual_mode) begin
            t_d.flags = t_d.flags | complete_vec;
            t_d.seen  = '0;
        end else begin
            seen_nxt = (t_q.seen | complete_vec) & en_vec;
            if ((|complete_vec) && (seen_nxt == en_vec)) begin
                t_d.flags[0] = 1'b1;
                t_d.seen     = '0;
            end else begin
                t_d.seen = seen_nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.ctrl  <= '0;
            t_q.flags <= '0;
            t_q.seen  <= '0;
            t_q.we    <= 1'b0;
            t_q.addr  <= '0;
            t_q.data  <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign cfg_rdata  = t_q.ctrl;
    assign buf_we     = t_q.we;
    assign buf_addr   = t_q.addr;
    assign buf_wdata  = t_q.data;
    assign dis_strobe = strobe_vec;
    assign irq_flags  = t_q.flags;
    assign irq        = |(t_q.flags & ie_vec);
endmodule

// File: rtl/shdual_chk.sv
module shdual_chk
    import shdual_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int SLOT0  = 23,
    parameter int SLOT1  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cfg_rdata,
    input logic [1:0]        flag_clr,
    input logic              volt_gnt,
    input logic              adc_req_valid,
    input logic              adc_req_ch,
    input logic              buf_we,
    input logic [ADDR_W-1:0] buf_addr,
    input logic [15:0]       buf_wdata,
    input logic [1:0]        dis_strobe,
    input logic [1:0]        irq_flags
);
    p_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (buf_addr == ADDR_W'(SLOT0) || buf_addr == ADDR_W'(SLOT1)));

    p_wr_en0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && buf_addr == ADDR_W'(SLOT0)) |-> $past(cfg_rdata[CB_EN0]));

    p_wr_en1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && buf_addr == ADDR_W'(SLOT1)) |-> $past(cfg_rdata[CB_EN1]));

    p_req_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_req_valid |-> (adc_req_ch ? cfg_rdata[CB_EN1] : cfg_rdata[CB_EN0]));

    p_left0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && buf_addr == ADDR_W'(SLOT0) && $past(cfg_rdata[CB_ALN0]))
        |-> (buf_wdata[1:0] == 2'b00));

    p_right0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && buf_addr == ADDR_W'(SLOT0) && !$past(cfg_rdata[CB_ALN0]))
        |-> (buf_wdata[15:14] == {2{buf_wdata[13]}}));

    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        adc_req_valid |-> !volt_gnt);

    p_disc0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dis_strobe[0]) |-> ($past(cfg_rdata[CB_DIS0]) && buf_we && buf_addr == ADDR_W'(SLOT0)));

    p_disc1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dis_strobe[1]) |-> ($past(cfg_rdata[CB_DIS1]) && buf_we && buf_addr == ADDR_W'(SLOT1)));

    p_single_f1_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flags[1]) |-> $past(cfg_rdata[CB_DUAL]));

    p_sticky0_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flags[0] && !flag_clr[0]) |=> irq_flags[0]);

    p_sticky1_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flags[1] && !flag_clr[1]) |=> irq_flags[1]);

    p_resv_r13: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[15:10] == 6'd0);
endmodule

bind shdual_ctrl shdual_chk #(
    .ADDR_W(ADDR_W),
    .SLOT0 (SLOT0),
    .SLOT1 (SLOT1)
) u_shdual_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_rdata    (cfg_rdata),
    .flag_clr     (flag_clr),
    .volt_gnt     (volt_gnt),
    .adc_req_valid(adc_req_valid),
    .adc_req_ch   (adc_req_ch),
    .buf_we       (buf_we),
    .buf_addr     (buf_addr),
    .buf_wdata    (buf_wdata),
    .dis_strobe   (dis_strobe),
    .irq_flags    (irq_flags)
);

// File: tb/tb_shdual_ctrl.sv
module tb_shdual_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PERIOD     = 16;
    localparam int DISC       = 3;
    localparam int LAT        = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [1:0]  flag_clr = '0;
    logic [1:0]  trig_in = '0;
    logic        volt_req = 1'b0;
    logic        volt_gnt;
    logic        adc_req_valid;
    logic        adc_req_ready = 1'b1;
    logic        adc_req_ch;
    logic        adc_done = 1'b0;
    logic        adc_done_ch = 1'b0;
    logic [13:0] adc_result = '0;
    logic        buf_we;
    logic [4:0]  buf_addr;
    logic [15:0] buf_wdata;
    logic [1:0]  dis_strobe;
    logic [1:0]  irq_flags;
    logic        irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    shdual_ctrl #(
        .PERIOD_TICKS(PERIOD),
        .DIS_CYCLES  (DISC),
        .ADDR_W      (5),
        .SLOT0       (23),
        .SLOT1       (24)
    ) dut (.*);

    int n_chk = 0;
    int n_bad = 0;
    int hs_cnt[2];
    int wr_cnt[2];
    int dis_cnt[2];
    int vg_cnt = 0;
    int conflict_cnt = 0;
    logic [15:0] last_data[2];
    logic [15:0] ctrl_sh = '0;
    bit  rand_ready = 0;
    bit  use_fixed = 0;
    logic [13:0] fixed_res = '0;
    bit  finished = 0;

    function automatic logic [15:0] expect_word(input logic [13:0] r, input logic left);
        return left ? {r, 2'b00} : {{2{r[13]}}, r};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // converter model and result scoreboard, active on falling edges
    int         lat = 0;
    bit         done_drv = 0;
    logic       cur_ch = 0;
    logic [4:0] exp_addr;
    logic [15:0] exp_data;

    initial begin
        for (int i = 0; i < 2; i++) begin
            hs_cnt[i] = 0; wr_cnt[i] = 0; dis_cnt[i] = 0; last_data[i] = '0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (done_drv) begin
                chk(buf_we === 1'b1 && buf_addr == exp_addr && buf_wdata == exp_data,
                    "R4 R5 buffer write", {11'd0, buf_we, buf_addr, buf_wdata}, {11'd1, 1'b1, exp_addr, exp_data});
                wr_cnt[cur_ch] = wr_cnt[cur_ch] + 1;
                last_data[cur_ch] = buf_wdata;
                adc_done = 1'b0;
                done_drv = 0;
            end else if (buf_we) begin
                chk(1'b0, "R3 unexpected buffer write", {27'd0, buf_addr}, 32'd0);
            end
            for (int i = 0; i < 2; i++) if (dis_strobe[i]) dis_cnt[i]++;
            if (volt_gnt) vg_cnt++;
            if (volt_gnt && adc_req_valid) conflict_cnt++;
            if (lat > 0) begin
                lat--;
                if (lat == 0) begin
                    adc_result  = use_fixed ? fixed_res : 14'($urandom);
                    adc_done    = 1'b1;
                    adc_done_ch = cur_ch;
                    exp_addr    = cur_ch ? 5'd24 : 5'd23;
                    exp_data    = expect_word(adc_result, cur_ch ? ctrl_sh[4] : ctrl_sh[3]);
                    done_drv    = 1;
                end
            end
            if (adc_req_valid && adc_req_ready) begin
                chk(ctrl_sh[adc_req_ch ? 1 : 0] == 1'b1, "R3 request from disabled channel",
                    {31'd0, adc_req_ch}, 32'd0);
                hs_cnt[adc_req_ch ? 1 : 0]++;
                cur_ch = adc_req_ch;
                lat = LAT;
            end
            adc_req_ready = rand_ready ? ($urandom % 4 != 0) : 1'b1;
        end
    end

    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) tick();
    endtask

    task automatic cfg(input logic [15:0] v);
        cfg_wdata = v;
        cfg_we = 1'b1;
        tick();
        cfg_we = 1'b0;
        ctrl_sh = v & 16'h03FF;
    endtask

    task automatic clr(input logic [1:0] m);
        flag_clr = m;
        tick();
        flag_clr = '0;
    endtask

    task automatic pulse(input logic [1:0] t);
        trig_in = t;
        tick();
        trig_in = '0;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int w0, w1, h0, h1, v0, vn, dn, df;
        void'($urandom(32'd4242));
        wait_cyc(5);
        rst_n = 1'b1;
        tick();

        // R13 reset values
        chk(cfg_rdata == 16'h0, "R13 reset control", cfg_rdata, 0);
        chk(irq_flags == 2'b00 && irq == 1'b0, "R13 reset flags", {irq_flags, irq}, 0);
        chk(dis_strobe == 2'b00 && adc_req_valid == 1'b0 && buf_we == 1'b0,
            "R13 reset outputs", {dis_strobe, adc_req_valid, buf_we}, 0);
        cfg(16'hFFFF);
        chk(cfg_rdata == 16'h03FF, "R13 reserved bits read zero", cfg_rdata, 16'h03FF);
        cfg(16'h0000);
        wait_cyc(20);
        clr(2'b11);

        // R1 R11 R5 R8: single mode, both channels, ch0 left+discharge, ch1 right
        use_fixed = 1; fixed_res = 14'h2001;
        cfg(16'h00A9); // en0 en1? 0xA9 = bits 0,3,5,7 -> add en1
        cfg(16'h00AB); // en0 en1 aln0 ie0 dis0
        w0 = wr_cnt[0]; w1 = wr_cnt[1];
        dis_cnt[0] = 0; dis_cnt[1] = 0;
        pulse(2'b01);
        for (int k = 0; k < 200 && wr_cnt[0] == w0; k++) tick();
        chk(irq_flags[0] == 1'b0, "R11 flag held until all channels done", irq_flags, 0);
        for (int k = 0; k < 200 && wr_cnt[1] == w1; k++) tick();
        tick();
        chk(wr_cnt[0] == w0 + 1 && wr_cnt[1] == w1 + 1, "R1 single trigger starts both",
            {wr_cnt[0] - w0, wr_cnt[1] - w1}, {32'd1});
        chk(irq_flags == 2'b01, "R11 single completion flag", irq_flags, 2'b01);
        chk(irq == 1'b1, "R12 irq follows enabled flag", irq, 1);
        chk(last_data[0] == 16'h8004, "R5 left justified", last_data[0], 16'h8004);
        chk(last_data[1] == 16'hE001, "R5 right justified sign extend", last_data[1], 16'hE001);
        wait_cyc(10);
        chk(dis_cnt[0] == DISC && dis_cnt[1] == 0, "R8 discharge length",
            {dis_cnt[0][15:0], dis_cnt[1][15:0]}, {16'(DISC), 16'd0});
        clr(2'b01);
        chk(irq_flags == 2'b00 && irq == 1'b0, "R12 write one clears flag", {irq_flags, irq}, 0);
        use_fixed = 0;

        // R1: single mode ignores trigger line 1
        h0 = hs_cnt[0]; h1 = hs_cnt[1];
        pulse(2'b10);
        wait_cyc(3 * PERIOD + 10);
        chk(hs_cnt[0] == h0 && hs_cnt[1] == h1, "R1 line 1 ignored in single mode",
            hs_cnt[0] + hs_cnt[1] - h0 - h1, 0);

        // R2 R10 R12: dual mode, trigger line 1 only
        cfg(16'h0027);
        clr(2'b11);
        w0 = wr_cnt[0]; w1 = wr_cnt[1];
        pulse(2'b10);
        wait_cyc(60);
        chk(wr_cnt[1] == w1 + 1 && wr_cnt[0] == w0, "R2 dual routes line 1 to ch1",
            {wr_cnt[1] - w1, wr_cnt[0] - w0}, {32'd1, 32'd0});
        chk(irq_flags == 2'b10, "R10 dual flag per channel", irq_flags, 2'b10);
        chk(irq == 1'b0, "R12 masked flag gives no irq", irq, 0);
        cfg(16'h0067);
        chk(irq == 1'b1, "R12 enabling mask raises irq", irq, 1);
        pulse(2'b01);
        wait_cyc(60);
        chk(irq_flags == 2'b11 && wr_cnt[0] == w0 + 1, "R10 R2 dual ch0 flag", irq_flags, 2'b11);
        clr(2'b11);

        // R3: disabled channel ignores trigger
        cfg(16'h0006);
        h0 = hs_cnt[0]; w0 = wr_cnt[0];
        pulse(2'b01);
        wait_cyc(60);
        chk(hs_cnt[0] == h0 && wr_cnt[0] == w0, "R3 disabled channel idle", hs_cnt[0] - h0, 0);

        // R9: retrigger while busy is ignored
        cfg(16'h0005);
        h0 = hs_cnt[0];
        pulse(2'b01);
        tick();
        pulse(2'b01);
        wait_cyc(60);
        chk(hs_cnt[0] == h0 + 1, "R9 retrigger ignored while busy", hs_cnt[0] - h0, 1);

        // R6: normal mode, one slot per period
        volt_req = 1'b1;
        wait_cyc(40);
        h0 = hs_cnt[0]; v0 = vg_cnt;
        trig_in = 2'b01;
        wait_cyc(8 * PERIOD);
        trig_in = 2'b00;
        dn = hs_cnt[0] - h0; vn = vg_cnt - v0;
        chk(dn >= 7 && dn <= 9, "R6 one conversion per period", dn, 8);
        chk(vn > 4 * PERIOD, "R6 voltage served between slots", vn, 4 * PERIOD);
        wait_cyc(40);

        // R7: fast mode
        cfg(16'h0205);
        conflict_cnt = 0;
        h0 = hs_cnt[0]; v0 = vg_cnt;
        trig_in = 2'b01;
        wait_cyc(8 * PERIOD);
        trig_in = 2'b00;
        df = hs_cnt[0] - h0;
        chk(df >= 12, "R7 fast mode ignores period slots", df, 12);
        chk(vg_cnt - v0 < vn, "R7 fast mode delays voltage", vg_cnt - v0, vn);
        chk(conflict_cnt == 0, "R7 no grant during request", conflict_cnt, 0);
        volt_req = 1'b0;
        wait_cyc(60);

        // random rounds, scoreboard checks every write (R3 R4 R5)
        rand_ready = 1;
        for (int it = 0; it < 30; it++) begin
            cfg(16'($urandom) & 16'h03FF);
            for (int k = 0; k < 60; k++) begin
                trig_in = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
                volt_req = 1'($urandom);
                tick();
            end
            trig_in = 2'b00;
            wait_cyc(120);
            clr(2'b11);
        end
        rand_ready = 0;
        chk(wr_cnt[0] + wr_cnt[1] == hs_cnt[0] + hs_cnt[1], "R4 every conversion written",
            wr_cnt[0] + wr_cnt[1], hs_cnt[0] + hs_cnt[1]);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule